// File: doc/BRIEF.md
# Parallel-Port Link Wake and Release Sequencer

This block brings a bridge chip that sits behind a parallel port into its active state and later hands the port back. A connect request first records the values the host currently drives on the data port and the control port. It then plays a fixed wake-up pattern on those lines. When the selected transfer mode is one of the enhanced (EPP) modes, it plays a further initialization pattern. It finishes by issuing one configuration write through a register-write request interface. A disconnect request plays a short release pattern that ends with the recorded data and control values back on the port.

Every step changes either the data lines or the control lines, never both. A one-cycle strobe marks the step on the lines it drives. Each step dwells for a delay that is programmable per sequence, so slow bridges can follow. The register-write request follows valid/ready rules. Once `reg_wr_valid` rises, address and data stay fixed until the cycle in which `reg_wr_ready` is high. The sequencer waits through back-pressure for as long as it lasts. A disconnect that arrives while a connect is still running is remembered and starts as soon as the connect completes.

Top module: `plink_wake_seq`

## Requirements
- R1: While reset is asserted and after it is released, `data_out` is 0x00, `ctrl_out` is 0x04, and `data_stb`, `ctrl_stb`, `reg_wr_valid`, `busy` and `done` are all low.
- R2: When a connect is accepted (`conn_req` high while idle), the values on `data_in` and `ctrl_in` in that cycle are recorded. They are kept unchanged until the next accepted connect, whatever the inputs do later.
- R3: A connect drives this wake pattern in order: control 0x04; data 0xA0, 0x50, 0xC0, 0x30, 0xA0, 0x00; control 0x01; control 0x04. Each step raises exactly one strobe (`data_stb` for data, `ctrl_stb` for control) for one cycle, in the cycle its new value first appears.
- R4: If `mode` was 3 or more when the connect was accepted, ten more steps follow the wake pattern: data 0x0A; control 0x01, 0x04; data 0x82; control 0x04, 0x0C, 0x04, 0x24, 0x26, 0x04. For modes 0 to 2 there are no extra steps.
- R5: `step_dly` is captured when a sequence starts, and each step lasts `step_dly`+1 cycles. The first step's value appears one clock edge after the request is accepted. Changes to `step_dly` or `mode` during a sequence have no effect on it.
- R6: After the last connect step, `reg_wr_valid` rises with `reg_wr_addr` = 0x86 and `reg_wr_data` = 0x08. It stays high with both fields stable until a cycle with `reg_wr_ready` high.
- R7: `done` is a one-cycle pulse. For a connect it comes in the cycle after the write handshake; for a disconnect, in the cycle after its last step ends. `busy` is high from the cycle after acceptance through the `done` cycle.
- R8: A disconnect drives: recorded data; control 0x01; control 0x04; recorded data; recorded control. It raises the same strobes as R3.
- R9: A `disc_req` seen in any cycle of a connect (including the accept cycle and its `done` cycle) is queued. The disconnect is accepted in the connect's `done` cycle, so `busy` stays high between the two.
- R10: `conn_req` is ignored while busy. `disc_req` is ignored while a disconnect runs. `disc_req` alone while idle starts a disconnect using the values recorded by the last connect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conn_req | input | 1 | Request to wake the bridge |
| disc_req | input | 1 | Request to release the port |
| mode | input | 3 | Transfer mode; 3 and above select the EPP extension |
| step_dly | input | DLYW | Extra dwell cycles per step |
| data_in | input | PW | Current data-port value, recorded on connect |
| ctrl_in | input | PW | Current control-port value, recorded on connect |
| data_out | output | PW | Value driven on the data port |
| data_stb | output | 1 | One-cycle mark of a new data value |
| ctrl_out | output | PW | Value driven on the control port |
| ctrl_stb | output | 1 | One-cycle mark of a new control value |
| reg_wr_valid | output | 1 | Configuration write request valid |
| reg_wr_ready | input | 1 | Configuration write accepted |
| reg_wr_addr | output | AW | Configuration register address |
| reg_wr_data | output | PW | Configuration value |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench changes `step_dly`, `mode`, `data_in` and `ctrl_in` after acceptance. A design that sampled them late would stretch the dwell, play or skip the EPP steps, or restore the wrong values on release. The bench holds `reg_wr_ready` low for several cycles. A design that dropped or changed the request under back-pressure would lose the configuration write. Disconnect requests land mid-connect, together with a connect in the idle cycle, and during a disconnect. A design that lost the queued request would leave the port held. One that acted on the late request would release twice. Zero dwell, where each step's first and last cycle coincide, is run against longer dwells to catch off-by-one step lengths.

// File: rtl/plink_pkg.sv
package plink_pkg;
  localparam int IDXW      = 5;
  localparam int CONN_BASE = 9;
  localparam int CONN_EPP  = 19;
  localparam int DISC_LEN  = 5;
  localparam int EPP_MODE  = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_REGW, ST_DONE} seq_st_e;
  typedef enum logic [1:0] {SRC_LIT, SRC_SDATA, SRC_SCTRL} val_src_e;

  typedef struct packed {
    logic     to_ctrl;
    val_src_e src;
    logic [7:0] lit;
  } step_t;
endpackage

// File: rtl/plink_step_rom.sv
module plink_step_rom
  import plink_pkg::*;
(
  input  logic            is_disc,
  input  logic [IDXW-1:0] idx,
  output step_t           step
);
  function automatic step_t mk(input logic c, input val_src_e s, input logic [7:0] v);
    step_t r;
    r.to_ctrl = c;
    r.src     = s;
    r.lit     = v;
    return r;
  endfunction

  always_comb begin
    step = mk(1'b1, SRC_LIT, 8'h04);
    if (is_disc) begin
      case (idx)
        5'd0:    step = mk(1'b0, SRC_SDATA, 8'h00);
        5'd1:    step = mk(1'b1, SRC_LIT,   8'h01);
        5'd2:    step = mk(1'b1, SRC_LIT,   8'h04);
        5'd3:    step = mk(1'b0, SRC_SDATA, 8'h00);
        default: step = mk(1'b1, SRC_SCTRL, 8'h00);
      endcase
    end else begin
      case (idx)
        5'd0:    step = mk(1'b1, SRC_LIT, 8'h04);
        5'd1:    step = mk(1'b0, SRC_LIT, 8'hA0);
        5'd2:    step = mk(1'b0, SRC_LIT, 8'h50);
        5'd3:    step = mk(1'b0, SRC_LIT, 8'hC0);
        5'd4:    step = mk(1'b0, SRC_LIT, 8'h30);
        5'd5:    step = mk(1'b0, SRC_LIT, 8'hA0);
        5'd6:    step = mk(1'b0, SRC_LIT, 8'h00);
        5'd7:    step = mk(1'b1, SRC_LIT, 8'h01);
        5'd8:    step = mk(1'b1, SRC_LIT, 8'h04);
        5'd9:    step = mk(1'b0, SRC_LIT, 8'h0A);
        5'd10:   step = mk(1'b1, SRC_LIT, 8'h01);
        5'd11:   step = mk(1'b1, SRC_LIT, 8'h04);
        5'd12:   step = mk(1'b0, SRC_LIT, 8'h82);
        5'd13:   step = mk(1'b1, SRC_LIT, 8'h04);
        5'd14:   step = mk(1'b1, SRC_LIT, 8'h0C);
        5'd15:   step = mk(1'b1, SRC_LIT, 8'h04);
        5'd16:   step = mk(1'b1, SRC_LIT, 8'h24);
        5'd17:   step = mk(1'b1, SRC_LIT, 8'h26);
        default: step = mk(1'b1, SRC_LIT, 8'h04);
      endcase
    end
  end
endmodule

// File: rtl/plink_dwell.sv
module plink_dwell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] lim_in,
  output logic         first,
  output logic         last
);
  logic [W-1:0] cnt;
  logic [W-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lim <= '0;
    end else if (load) begin
      cnt <= '0;
      lim <= lim_in;
    end else if (run) begin
      cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
    end
  end

  assign first = (cnt == '0);
  assign last  = (cnt == lim);
endmodule

// File: rtl/plink_wake_seq.sv
module plink_wake_seq
  import plink_pkg::*;
#(
  parameter int PW   = 8,
  parameter int DLYW = 8,
  parameter int AW   = 8,
  parameter logic [AW-1:0] CFG_ADDR = 8'h86,
  parameter logic [PW-1:0] CFG_VAL  = 8'h08
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            conn_req,
  input  logic            disc_req,
  input  logic [2:0]      mode,
  input  logic [DLYW-1:0] step_dly,
  input  logic [PW-1:0]   data_in,
  input  logic [PW-1:0]   ctrl_in,
  output logic [PW-1:0]   data_out,
  output logic            data_stb,
  output logic [PW-1:0]   ctrl_out,
  output logic            ctrl_stb,
  output logic            reg_wr_valid,
  input  logic            reg_wr_ready,
  output logic [AW-1:0]   reg_wr_addr,
  output logic [PW-1:0]   reg_wr_data,
  output logic            busy,
  output logic            done
);
  localparam logic [IDXW-1:0] LAST_BASE = IDXW'(CONN_BASE - 1);
  localparam logic [IDXW-1:0] LAST_EPP  = IDXW'(CONN_EPP - 1);
  localparam logic [IDXW-1:0] LAST_DISC = IDXW'(DISC_LEN - 1);
  localparam logic [PW-1:0]   CTRL_RST  = PW'(8'h04);

  seq_st_e         st;
  logic            is_disc, epp, pend;
  logic [IDXW-1:0] idx, last_idx;
  logic [PW-1:0]   sav_d, sav_c, step_val;
  logic            start_conn, start_disc, d_first, d_last;
  step_t           step;

  assign start_conn = (st == ST_IDLE) && conn_req;
  assign start_disc = ((st == ST_IDLE) && !conn_req && disc_req) ||
                      ((st == ST_DONE) && !is_disc && (pend || disc_req));
  assign last_idx   = is_disc ? LAST_DISC : (epp ? LAST_EPP : LAST_BASE);

  plink_step_rom u_rom (.is_disc(is_disc), .idx(idx), .step(step));

  plink_dwell #(.W(DLYW)) u_dwell (
    .clk(clk), .rst_n(rst_n),
    .load(start_conn || start_disc),
    .run(st == ST_RUN),
    .lim_in(step_dly),
    .first(d_first), .last(d_last)
  );

  always_comb begin
    case (step.src)
      SRC_SDATA: step_val = sav_d;
      SRC_SCTRL: step_val = sav_c;
      default:   step_val = PW'(step.lit);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      is_disc  <= 1'b0;
      epp      <= 1'b0;
      pend     <= 1'b0;
      idx      <= '0;
      sav_d    <= '0;
      sav_c    <= '0;
      data_out <= '0;
      ctrl_out <= CTRL_RST;
      data_stb <= 1'b0;
      ctrl_stb <= 1'b0;
    end else begin
      data_stb <= 1'b0;
      ctrl_stb <= 1'b0;
      if (start_conn) begin
        sav_d   <= data_in;
        sav_c   <= ctrl_in;
        epp     <= (mode >= 3'(EPP_MODE));
        is_disc <= 1'b0;
        pend    <= disc_req;
        idx     <= '0;
        st      <= ST_RUN;
      end else if (start_disc) begin
        is_disc <= 1'b1;
        pend    <= 1'b0;
        idx     <= '0;
        st      <= ST_RUN;
      end else begin
        if (!is_disc && disc_req && (st != ST_IDLE)) pend <= 1'b1;
        case (st)
          ST_RUN: begin
            if (d_first) begin
              if (step.to_ctrl) begin
                ctrl_out <= step_val;
                ctrl_stb <= 1'b1;
              end else begin
                data_out <= step_val;
                data_stb <= 1'b1;
              end
            end
            if (d_last) begin
              if (idx == last_idx) st <= is_disc ? ST_DONE : ST_REGW;
              else idx <= idx + 1'b1;
            end
          end
          ST_REGW: if (reg_wr_ready) st <= ST_DONE;
          ST_DONE: st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign reg_wr_valid = (st == ST_REGW);
  assign reg_wr_addr  = CFG_ADDR;
  assign reg_wr_data  = CFG_VAL;
  assign busy         = (st != ST_IDLE);
  assign done         = (st == ST_DONE);
endmodule

// File: rtl/plink_wake_seq_chk.sv
module plink_wake_seq_chk #(
  parameter int PW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] data_out,
  input logic          data_stb,
  input logic [PW-1:0] ctrl_out,
  input logic          ctrl_stb,
  input logic          reg_wr_valid,
  input logic          reg_wr_ready,
  input logic [AW-1:0] reg_wr_addr,
  input logic [PW-1:0] reg_wr_data,
  input logic          busy,
  input logic          done
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_stb && ctrl_stb));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !data_stb) |-> $stable(data_out));

  assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !ctrl_stb) |-> $stable(ctrl_out));

  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_valid && !reg_wr_ready) |=>
      (reg_wr_valid && $stable(reg_wr_addr) && $stable(reg_wr_data)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!data_stb && !ctrl_stb && !reg_wr_valid));
endmodule

bind plink_wake_seq plink_wake_seq_chk #(.PW(PW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_out(data_out), .data_stb(data_stb),
  .ctrl_out(ctrl_out), .ctrl_stb(ctrl_stb), .reg_wr_valid(reg_wr_valid),
  .reg_wr_ready(reg_wr_ready), .reg_wr_addr(reg_wr_addr),
  .reg_wr_data(reg_wr_data), .busy(busy), .done(done)
);

// File: tb/sim_plink_wake_seq.sv
`timescale 1ns/1ps
module sim_plink_wake_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conn_req = 0, disc_req = 0, reg_wr_ready = 1;
  logic [2:0] mode = 0;
  logic [7:0] step_dly = 0, data_in = 0, ctrl_in = 0;
  logic [7:0] data_out, ctrl_out, reg_wr_addr, reg_wr_data;
  logic data_stb, ctrl_stb, reg_wr_valid, busy, done;

  int checks = 0, errors = 0, cycles = 0;
  int strobes = 0, dones = 0;

  always #10 clk = ~clk;

  plink_wake_seq u0 (
    .clk(clk), .rst_n(rst_n), .conn_req(conn_req), .disc_req(disc_req),
    .mode(mode), .step_dly(step_dly), .data_in(data_in), .ctrl_in(ctrl_in),
    .data_out(data_out), .data_stb(data_stb), .ctrl_out(ctrl_out),
    .ctrl_stb(ctrl_stb), .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: a queue of per-cycle actions (-1 = hold, else {ctrl,val}).
  int q[$];
  int mph = 0;            // 0 idle, 1 steps, 2 write request, 3 done
  bit mdisc = 0, mpend = 0;
  int sd = 0, sc = 0;
  int ed = 0, ec = 4;
  bit eds = 0, ecs = 0;

  function automatic void push_steps(input int vals[$], input int d);
    foreach (vals[i]) begin
      q.push_back(vals[i]);
      for (int j = 0; j < d; j++) q.push_back(-1);
    end
  endfunction

  function automatic void build_conn(input bit epp, input int d);
    int v[$];
    v = '{'h104, 'hA0, 'h50, 'hC0, 'h30, 'hA0, 'h00, 'h101, 'h104};
    if (epp) v = {v, '{'h0A, 'h101, 'h104, 'h82, 'h104, 'h10C, 'h104, 'h124, 'h126, 'h104}};
    push_steps(v, d);
  endfunction

  function automatic void build_disc(input int d);
    int v[$];
    v = '{sd, 'h101, 'h104, sd, 'h100 | sc};
    push_steps(v, d);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); mph = 0; mdisc = 0; mpend = 0; sd = 0; sc = 0;
      ed = 0; ec = 4; eds = 0; ecs = 0;
    end else begin
      eds = 0; ecs = 0;
      case (mph)
        0: if (conn_req) begin
             sd = data_in; sc = ctrl_in; mdisc = 0; mpend = disc_req;
             build_conn(mode >= 3, step_dly); mph = 1;
           end else if (disc_req) begin
             mdisc = 1; build_disc(step_dly); mph = 1;
           end
        1: begin
             int a;
             if (!mdisc && disc_req) mpend = 1;
             a = q.pop_front();
             if (a >= 0) begin
               if (a[8]) begin ec = a & 'hFF; ecs = 1; end
               else      begin ed = a & 'hFF; eds = 1; end
             end
             if (q.size() == 0) mph = mdisc ? 3 : 2;
           end
        2: begin
             if (!mdisc && disc_req) mpend = 1;
             if (reg_wr_ready) mph = 3;
           end
        default: begin
             if (!mdisc && (mpend || disc_req)) begin
               mdisc = 1; mpend = 0; build_disc(step_dly); mph = 1;
             end else mph = 0;
           end
      endcase
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      strobes += data_stb + ctrl_stb;
      dones   += done;
      chk(data_out == ed[7:0], "R3", "data_out", data_out, ed);
      chk(ctrl_out == ec[7:0], "R8", "ctrl_out", ctrl_out, ec);
      chk(data_stb == eds && ctrl_stb == ecs, "R5", "strobes",
          {data_stb, ctrl_stb}, {eds, ecs});
      chk(reg_wr_valid == (mph == 2), "R6", "reg_wr_valid", reg_wr_valid, mph == 2);
      chk(busy == (mph != 0) && done == (mph == 3), "R7", "busy/done",
          {busy, done}, {mph != 0, mph == 3});
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_conn();
    conn_req = 1; tick(1); conn_req = 0;
  endtask

  task automatic pulse_disc();
    disc_req = 1; tick(1); disc_req = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) tick(1);
  endtask

  initial begin
    int n, s0, d0;
    tick(2);
    chk(data_out == 8'h00 && ctrl_out == 8'h04, "R1", "reset ports",
        {data_out, ctrl_out}, 16'h0004);
    chk(!busy && !done && !reg_wr_valid && !data_stb && !ctrl_stb, "R1", "reset flags",
        {busy, done, reg_wr_valid, data_stb, ctrl_stb}, 0);
    rst_n = 1; tick(2);
    chk(ctrl_out == 8'h04 && !busy, "R1", "after release", ctrl_out, 8'h04);

    // Mode 0, dwell 2: count busy cycles and strobes (R3, R5, R7).
    mode = 0; step_dly = 2; data_in = 8'h5A; ctrl_in = 8'hC3; s0 = strobes;
    pulse_conn();
    n = 0;
    while (busy && n < 1000) begin n++; tick(1); end
    chk(n == 9*3 + 2, "R5", "busy cycles mode0", n, 9*3 + 2);
    chk(strobes - s0 == 9, "R3", "wake step count", strobes - s0, 9);

    // Mode 3, dwell 1, ready held low; change dwell and mode mid-run (R4, R5, R6).
    mode = 3; step_dly = 1; data_in = 8'h3C; ctrl_in = 8'h0E; reg_wr_ready = 0; s0 = strobes;
    pulse_conn();
    step_dly = 5; mode = 0; data_in = 8'hFF; ctrl_in = 8'hFF;
    n = 0;
    while (!reg_wr_valid && n < 1000) begin n++; tick(1); end
    chk(n == 19*2, "R5", "cycles to write request", n, 19*2);
    chk(strobes - s0 == 19, "R4", "epp step count", strobes - s0, 19);
    for (int i = 0; i < 4; i++) begin
      chk(reg_wr_valid && reg_wr_addr == 8'h86 && reg_wr_data == 8'h08, "R6",
          "held request", {reg_wr_valid, reg_wr_addr, reg_wr_data}, 17'h18608);
      tick(1);
    end
    reg_wr_ready = 1;
    wait_idle();

    // Disconnect from idle restores the recorded values (R2, R8, R10).
    step_dly = 0; s0 = strobes; d0 = dones;
    pulse_disc(); wait_idle();
    chk(data_out == 8'h3C, "R2", "restored data", data_out, 8'h3C);
    chk(ctrl_out == 8'h0E, "R8", "restored ctrl", ctrl_out, 8'h0E);
    chk(strobes - s0 == 5 && dones - d0 == 1, "R8", "release steps/done",
        strobes - s0, 5);

    // Queued disconnect and ignored connect during a connect (R9, R10).
    mode = 1; data_in = 8'h11; ctrl_in = 8'h22; s0 = strobes; d0 = dones;
    pulse_conn(); tick(2);
    data_in = 8'h99; pulse_conn(); pulse_disc(); data_in = 8'h11;
    n = 0;
    while (dones - d0 < 1 && n < 1000) begin n++; tick(1); end
    chk(busy, "R9", "busy kept into queued release", busy, 1);
    wait_idle();
    chk(dones - d0 == 2 && strobes - s0 == 14, "R9", "connect then release",
        strobes - s0, 14);
    chk(data_out == 8'h11 && ctrl_out == 8'h22, "R10", "late connect ignored",
        {data_out, ctrl_out}, 16'h1122);

    // Second disconnect request during a disconnect is ignored (R10).
    d0 = dones; step_dly = 3;
    pulse_disc(); tick(3); pulse_disc(); wait_idle(); tick(10);
    chk(dones - d0 == 1 && !busy, "R10", "extra release ignored", dones - d0, 1);

    // Connect and disconnect in the same idle cycle, mode 5 (R4, R9).
    mode = 5; step_dly = 0; data_in = 8'h47; ctrl_in = 8'h0B; s0 = strobes; d0 = dones;
    conn_req = 1; disc_req = 1; tick(1); conn_req = 0; disc_req = 0;
    wait_idle();
    chk(dones - d0 == 2 && strobes - s0 == 24, "R9", "same-cycle requests",
        strobes - s0, 24);
    chk(data_out == 8'h47 && ctrl_out == 8'h0B, "R2", "final restore",
        {data_out, ctrl_out}, 16'h470B);

    tick(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule